// File: doc/BRIEF.md
# Multi-Source Frame Sync Trigger

This block produces the single-cycle event that starts or realigns a frame timing engine. Three sources can raise that event. The first is a periodic internal source: a free-running counter that fires and restarts each time it reaches a programmable offset. The second is an external sync input, which can pass through a resynchronizer before an edge detector. The third is a software trigger bit that clears itself. Each source has its own enable. The merged event leaves the block on one registered output.

The offset for the internal source comes in as two 32-bit configuration words. The block uses the low `CNT_W` bits of the combined 64-bit value. Build parameters remove the internal path (`CNT_W = 0`) or the external path. A second build parameter selects whether the external path has the resynchronizer. Configuration comes straight from register outputs, and the frame engine consumes `sync_pulse`.

Top module: `sync_trigger_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `sync_pulse` and `sw_pending` are 0.
- R2: While `int_enable` is high and the offset is held constant, the internal source fires every offset+1 cycles. The first event comes offset+1 cycles after enabling. Each event appears on `sync_pulse` one cycle after the counter reaches the offset.
- R3: While `int_enable` is low, the internal counter is held at zero and the internal source raises no event. Enabling again starts a fresh period of offset+1 cycles.
- R4: The offset is the value {`offset_hi`, `offset_lo`} truncated to its low `CNT_W` bits. With `CNT_W` = 40, bits 31..8 of `offset_hi` have no effect on the period.
- R5: If the offset is lowered below the current count, the internal source fires on the next cycle and then restarts from zero.
- R6: With `ext_enable` high, a rising edge on `ext_sync_in` gives exactly one single-cycle `sync_pulse`, even if the input stays high. With the two-stage resynchronizer, that pulse appears at the third clock edge after the input rises.
- R7: With `ext_enable` low, `ext_sync_in` activity raises no `sync_pulse`.
- R8: A one-cycle `sw_trig_wr` strobe sets `sw_pending` at the next edge. At the edge after that, `sync_pulse` goes high for one cycle and `sw_pending` returns to 0.
- R9: `sync_pulse` is the registered OR of the enabled sources. Events from different sources in the same cycle give one single-cycle pulse, and with no source active it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_enable | input | 1 | Enable for the periodic internal source |
| ext_enable | input | 1 | Enable for the external source |
| sw_trig_wr | input | 1 | One-cycle strobe: software writes 1 to the trigger bit |
| offset_lo | input | 32 | Low word of the internal wrap offset |
| offset_hi | input | 32 | High word of the internal wrap offset |
| ext_sync_in | input | 1 | External sync input, possibly from another clock domain |
| sync_pulse | output | 1 | Merged single-cycle sync event |
| sw_pending | output | 1 | Self-clearing software trigger bit |

## Verification
The bench measures the internal period exactly at several offsets, including offset zero. An off-by-one compare or a counter that wraps one cycle late would shift every measured pulse. It lowers the offset below the running count; an equality-only compare would then run past the offset and never fire. It disables the source mid-period and re-enables it; a counter that merely freezes would fire early. It also holds the external input high; a level-sensitive path instead of an edge detector would give repeated pulses. Finally, it makes the internal and software events coincide, so a merge that drops or stretches either event is seen.

// File: rtl/sync_trig_pkg.sv
package sync_trig_pkg;

  localparam int OFFSET_WORDS_W = 64;

  // Join the two configuration words and keep only the low w bits.
  function automatic logic [63:0] join_offset(input logic [31:0] lo,
                                              input logic [31:0] hi,
                                              input int w);
    logic [63:0] full;
    logic [63:0] mask;
    full = {hi, lo};
    if (w >= 64) mask = '1;
    else mask = (64'd1 << w) - 64'd1;
    return full & mask;
  endfunction

  // The counter has reached (or passed) the offset.
  function automatic logic reached(input logic [63:0] cnt,
                                   input logic [63:0] off);
    return cnt >= off;
  endfunction

endpackage

// File: rtl/sync_period_cnt.sv
module sync_period_cnt
  import sync_trig_pkg::*;
#(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] off,
  output logic         hit
);

  logic [W-1:0] cnt;

  assign hit = en && reached(64'(cnt), 64'(off));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (!en || hit) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));
  // R2
  hit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0));
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hit) |=> (cnt == W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/sync_ext_cond.sv
module sync_ext_cond #(
  parameter int USE_CDC = 1,
  parameter int STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic raw,
  output logic evt
);

  logic sig;
  logic prev;

  generate
    if (USE_CDC != 0) begin : g_cdc
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else chain <= {chain[STAGES-2:0], raw};
      end
      assign sig = chain[STAGES-1];
    end else begin : g_direct
      assign sig = raw;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else prev <= sig;
  end

  assign evt = en && sig && !prev;

  // R6
  ext_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
  // R7
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !evt);

endmodule

// File: rtl/sync_soft_bit.sv
module sync_soft_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  output logic bit_q,
  output logic evt
);

  always_ff @(posedge clk) begin
    if (!rst_n) bit_q <= 1'b0;
    else bit_q <= wr;
  end

  assign evt = bit_q;

  // R8
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q && !wr) |=> !bit_q);
  // R8
  sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> bit_q);

endmodule

// File: rtl/sync_trigger_gen.sv
module sync_trigger_gen
  import sync_trig_pkg::*;
#(
  parameter int CNT_W      = 40,
  parameter int HAS_EXT    = 1,
  parameter int EXT_CDC    = 1,
  parameter int CDC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        int_enable,
  input  logic        ext_enable,
  input  logic        sw_trig_wr,
  input  logic [31:0] offset_lo,
  input  logic [31:0] offset_hi,
  input  logic        ext_sync_in,
  output logic        sync_pulse,
  output logic        sw_pending
);

  localparam int OFF_W = (CNT_W > 0) ? CNT_W : 1;

  logic int_hit;
  logic ext_evt;
  logic sw_evt;
  logic any_evt;

  generate
    if (CNT_W > 0) begin : g_int
      logic [63:0]    off_full;
      logic [OFF_W-1:0] off;
      assign off_full = join_offset(offset_lo, offset_hi, CNT_W);
      assign off      = off_full[OFF_W-1:0];
      sync_period_cnt #(.W(OFF_W)) u_period (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (int_enable),
        .off  (off),
        .hit  (int_hit)
      );
    end else begin : g_no_int
      assign int_hit = 1'b0;
    end

    if (HAS_EXT != 0) begin : g_ext
      sync_ext_cond #(.USE_CDC(EXT_CDC), .STAGES(CDC_STAGES)) u_ext (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ext_enable),
        .raw  (ext_sync_in),
        .evt  (ext_evt)
      );
    end else begin : g_no_ext
      assign ext_evt = 1'b0;
    end
  endgenerate

  sync_soft_bit u_soft (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (sw_trig_wr),
    .bit_q(sw_pending),
    .evt  (sw_evt)
  );

  assign any_evt = int_hit | ext_evt | sw_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_pulse <= 1'b0;
    else sync_pulse <= any_evt;
  end

  // R9
  pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> sync_pulse);
  // R9
  pulse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> !sync_pulse);
  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |=> (!sync_pulse && !sw_pending));

endmodule

// File: tb/tb_sync_trigger_gen.sv
module tb_sync_trigger_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_enable = 1'b0;
  logic        ext_enable = 1'b0;
  logic        sw_trig_wr = 1'b0;
  logic [31:0] offset_lo = '0;
  logic [31:0] offset_hi = '0;
  logic        ext_sync_in = 1'b0;
  logic        sync_pulse;
  logic        sw_pending;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sync_trigger_gen dut (
    .clk(clk), .rst_n(rst_n), .int_enable(int_enable), .ext_enable(ext_enable),
    .sw_trig_wr(sw_trig_wr), .offset_lo(offset_lo), .offset_hi(offset_hi),
    .ext_sync_in(ext_sync_in), .sync_pulse(sync_pulse), .sw_pending(sw_pending)
  );

  // {offset_lo, offset_hi, expected period}
  localparam logic [95:0] VEC [4] = '{
    {32'd3, 32'd0,          32'd4},
    {32'd0, 32'd0,          32'd1},
    {32'd7, 32'd0,          32'd8},
    {32'd5, 32'hFFFF_FF00,  32'd6}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int first;
    int second;
    int seen;
    step();
    check(sync_pulse == 1'b0, "R1 pulse in reset", sync_pulse, 0);
    check(sw_pending == 1'b0, "R1 pending in reset", sw_pending, 0);
    rst_n = 1'b1;
    step();
    check(sync_pulse == 1'b0 && sw_pending == 1'b0, "R1 after release",
          {sync_pulse, sw_pending}, 0);

    // R2 / R4: period table
    for (int v = 0; v < 4; v++) begin
      int per;
      int_enable = 1'b0;
      step(); step();
      offset_lo  = VEC[v][95:64];
      offset_hi  = VEC[v][63:32];
      per        = int'(VEC[v][31:0]);
      int_enable = 1'b1;
      first = 0; second = 0; seen = 0;
      for (int k = 1; k <= 2 * per + 1; k++) begin
        step();
        if (sync_pulse) begin
          if (seen == 0) first = k;
          else if (seen == 1) second = k;
          seen++;
        end
      end
      check(first == per, (v == 3) ? "R4 first pulse" : "R2 first pulse", first, per);
      check(second == 2 * per, (v == 3) ? "R4 second pulse" : "R2 second pulse",
            second, 2 * per);
    end

    // R3: disable mid-period, then restart
    int_enable = 1'b0;
    step(); step();
    offset_lo = 32'd4; offset_hi = 32'd0;
    int_enable = 1'b1;
    seen = 0;
    step(); step();
    int_enable = 1'b0;
    for (int k = 0; k < 3; k++) begin step(); if (sync_pulse) seen++; end
    int_enable = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      step();
      if (k < 5 && sync_pulse) seen++;
      if (k == 5) check(sync_pulse == 1'b1, "R3 restart pulse", sync_pulse, 1);
    end
    check(seen == 0, "R3 no early pulse", seen, 0);

    // R5: lower offset below running count
    int_enable = 1'b0;
    step(); step();
    offset_lo = 32'd10;
    int_enable = 1'b1;
    seen = 0;
    for (int k = 0; k < 6; k++) begin step(); if (sync_pulse) seen++; end
    offset_lo = 32'd2;
    step();
    check(sync_pulse == 1'b1 && seen == 0, "R5 immediate pulse", sync_pulse, 1);
    step(); seen = sync_pulse;
    step(); seen += sync_pulse;
    check(seen == 0, "R5 gap after restart", seen, 0);
    step();
    check(sync_pulse == 1'b1, "R5 next period", sync_pulse, 1);
    int_enable = 1'b0;
    step(); step();

    // R7: external disabled
    seen = 0;
    for (int k = 0; k < 4; k++) begin
      ext_sync_in = ~ext_sync_in;
      step(); step();
      if (sync_pulse) seen++;
      step();
      if (sync_pulse) seen++;
    end
    check(seen == 0, "R7 ext ignored", seen, 0);

    // R6: rising edge, held high
    ext_sync_in = 1'b0;
    ext_enable  = 1'b1;
    repeat (4) step();
    ext_sync_in = 1'b1;
    step(); first = sync_pulse;
    step(); first += sync_pulse;
    check(first == 0, "R6 before latency", first, 0);
    step();
    check(sync_pulse == 1'b1, "R6 pulse at third edge", sync_pulse, 1);
    seen = 0;
    for (int k = 0; k < 10; k++) begin step(); if (sync_pulse) seen++; end
    check(seen == 0, "R6 single pulse while held", seen, 0);
    ext_sync_in = 1'b0;
    repeat (4) step();
    ext_enable = 1'b0;

    // R8: software trigger
    sw_trig_wr = 1'b1;
    step();
    sw_trig_wr = 1'b0;
    check(sw_pending == 1'b1 && sync_pulse == 1'b0, "R8 bit set",
          {sw_pending, sync_pulse}, 2);
    step();
    check(sync_pulse == 1'b1 && sw_pending == 1'b0, "R8 pulse and clear",
          {sw_pending, sync_pulse}, 1);
    step();
    check(sync_pulse == 1'b0, "R8 one cycle", sync_pulse, 0);

    // R9: coincident internal and software events
    offset_lo = 32'd3;
    int_enable = 1'b1;
    step(); step();
    sw_trig_wr = 1'b1;
    step();
    sw_trig_wr = 1'b0;
    step();
    check(sync_pulse == 1'b1, "R9 merged pulse", sync_pulse, 1);
    step();
    check(sync_pulse == 1'b0, "R9 merged single cycle", sync_pulse, 0);
    int_enable = 1'b0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin step(); if (sync_pulse) seen++; end
    check(seen == 0, "R9 quiet when idle", seen, 0);

    finish_run();
  end

endmodule